// File: doc/BRIEF.md
# Register-Mapped SAR Conversion Sequencer

This block controls single conversions of a successive-approximation ADC front end with three analog inputs. Software programs a timing word (clock divider plus three phase lengths), writes a control word that picks an input and raises the enable bit, and the block then runs a startup phase, a sampling phase and a compare phase. Each phase lasts a programmable number of ticks of a divided conversion clock. The front end sees two handshake strobes, one during sampling and one during comparison, and returns its 12-bit code on a data input. Full scale of that code stands for 3300 mV.

When the compare phase finishes, the code is stored in a result register private to the converted input, together with a valid flag. Busy drops and an interrupt status bit is set. An interrupt line follows that status bit when software has enabled it, and software acknowledges it through a write-one-to-clear register. Registers are reached through a word-addressed port: the address is the byte offset divided by four. Reads are combinational.

Top module: `sar_seq`

## Requirements
- R1: After reset every register word (word indices 0 to 15) reads zero, the status busy bit is 0 and `irq` is low.
- R2: Word 1 (offset 0x04) is control: bit 0 enables, bits 5, 6 and 7 select inputs 0, 1 and 2. A write that takes bit 0 from 0 to 1 while idle, with at least one select bit set, starts a conversion. Bit 0 of word 2 (offset 0x08) reads 1 from the cycle after that write until the conversion ends.
- R3: Word 3 (offset 0x0C) holds the timing fields: startup length in bits [4:0], sample length in [11:8], divider in [15:12] and compare length in [19:16]. Other bits read zero.
- R4: With divider d and lengths s, w, c, busy stays high for exactly (s+1+w+1+c+1)·(d+1) clock cycles.
- R5: `afe_sample` is high for (w+1)·(d+1) cycles, starting (s+1)·(d+1) cycles after busy rises. `afe_convert` is then high for (c+1)·(d+1) cycles. The two strobes are never high together, and neither is high while idle.
- R6: The result of input n reads at word 5+n (offset 0x14+4·n). Bits [11:0] hold the `afe_data` value present in the last compare cycle, bit 15 is the valid flag, and the other bits are zero.
- R7: Starting a conversion clears the valid flag of the selected input only. The other inputs' results are unchanged.
- R8: When several select bits are set, the lowest-numbered selected input is converted.
- R9: Raising enable while busy does not restart or redirect the running conversion. Writing enable=1 again while it is already 1 does not start a conversion.
- R10: Interrupt status is bit 0 of word 10 (offset 0x28). It is set when a conversion ends. Writing 1 to bit 0 of word 9 (offset 0x24) clears it. When a clear and a conversion end fall on the same cycle, the status stays set.
- R11: `irq` is high exactly when interrupt status is set and bit 0 of word 8 (offset 0x20) is set.
- R12: Raising enable with no select bit set starts nothing.
- R13: Writes to status, result and interrupt-status words have no effect. Unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| afe_sample | output | 1 | Front end: track the selected input |
| afe_convert | output | 1 | Front end: run the comparison |
| afe_data | input | 12 | Front end conversion code |

## Verification
The bench sweeps the divider over all small values and sets each phase length at its minimum and maximum. It measures busy and strobe durations in cycles, so a design that is off by one tick, or that counts phases in system clocks instead of divided ticks, gives a wrong length. Select patterns cover every non-empty combination, which catches a priority encoder that picks the highest input or that writes a result into a neighbour's register. Retriggers while busy, a repeated enable with no falling edge, and an enable with no channel selected are all probed; a design that obeys any of them shows a changed busy length or a misplaced result. A clear that lands in the finishing cycle is aimed for exactly, and a design that gives the clear priority loses the interrupt.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_STARTUP, PH_SAMPLE, PH_COMPARE} phase_e;

  // Word indices of the register map (byte offset / 4)
  localparam int W_CTRL  = 1;
  localparam int W_STAT  = 2;
  localparam int W_TCFG  = 3;
  localparam int W_RES0  = 5;
  localparam int W_IEN   = 8;
  localparam int W_ICLR  = 9;
  localparam int W_ISTA  = 10;

  // Field geometry
  localparam int SEL_LSB   = 5;
  localparam int STUP_W    = 5;
  localparam int PH_W      = 4;
  localparam int STUP_LSB  = 0;
  localparam int SAMP_LSB  = 8;
  localparam int DIV_LSB   = 12;
  localparam int CMP_LSB   = 16;
  localparam int VALID_BIT = 15;

  // Ticks a full conversion needs for given phase fields
  function automatic int unsigned conv_ticks(input int unsigned s, w, c);
    return (s + 1) + (w + 1) + (c + 1);
  endfunction

  // System clock cycles for a full conversion
  function automatic int unsigned conv_cycles(input int unsigned s, w, c, d);
    return conv_ticks(s, w, c) * (d + 1);
  endfunction

  // Index of the lowest set bit among the first n bits of v
  function automatic int unsigned lowest_set(input logic [7:0] v, input int unsigned n);
    int unsigned idx;
    idx = 0;
    for (int i = int'(n) - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/sar_seq_tick.sv
module sar_seq_tick #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic [LW-1:0] len_stup,
  input  logic [LW-1:0] len_samp,
  input  logic [LW-1:0] len_cmp,
  output phase_e        phase,
  output logic          busy,
  output logic          done
);
  phase_e        phase_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] stup_q, samp_q, cmp_q;
  logic [LW-1:0] cur_len;
  logic          last_tick;

  always_comb begin
    case (phase_q)
      PH_STARTUP: cur_len = stup_q;
      PH_SAMPLE:  cur_len = samp_q;
      PH_COMPARE: cur_len = cmp_q;
      default:    cur_len = '0;
    endcase
  end

  assign last_tick = tick && (cnt_q == cur_len);
  assign done      = last_tick && (phase_q == PH_COMPARE);
  assign busy      = (phase_q != PH_IDLE);
  assign phase     = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      stup_q  <= '0;
      samp_q  <= '0;
      cmp_q   <= '0;
    end else if (start) begin
      phase_q <= PH_STARTUP;
      cnt_q   <= '0;
      stup_q  <= len_stup;
      samp_q  <= len_samp;
      cmp_q   <= len_cmp;
    end else if (last_tick) begin
      cnt_q <= '0;
      case (phase_q)
        PH_STARTUP: phase_q <= PH_SAMPLE;
        PH_SAMPLE:  phase_q <= PH_COMPARE;
        default:    phase_q <= PH_IDLE;
      endcase
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 12,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          afe_sample,
  output logic          afe_convert,
  input  logic [DW-1:0] afe_data
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  // Configuration and control state
  logic             ctrl_en_q;
  logic [NCH-1:0]   ctrl_sel_q;
  logic [STUP_W-1:0] t_stup_q;
  logic [PH_W-1:0]  t_samp_q, t_div_q, t_cmp_q;
  logic [PH_W-1:0]  div_lat_q;
  logic [CHW-1:0]   cur_ch_q;
  logic             ien_q, ista_q;
  logic [DW-1:0]    res_code_q [NCH];
  logic [NCH-1:0]   res_vld_q;

  // Named internal events
  logic             ctrl_wr, start_evt, done_evt, clr_evt, tick, busy;
  logic [NCH-1:0]   req_sel;
  logic [CHW-1:0]   start_ch;
  phase_e           phase;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign ctrl_wr   = reg_we && (reg_addr == AW'(W_CTRL));
  assign req_sel   = reg_wdata[SEL_LSB +: NCH];
  assign start_ch  = CHW'(lowest_set(8'(req_sel), NCH));
  assign start_evt = ctrl_wr && reg_wdata[0] && !ctrl_en_q && (|req_sel) && !busy;
  assign clr_evt   = reg_we && (reg_addr == AW'(W_ICLR)) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q  <= 1'b0;
      ctrl_sel_q <= '0;
      t_stup_q   <= '0;
      t_samp_q   <= '0;
      t_div_q    <= '0;
      t_cmp_q    <= '0;
      ien_q      <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == AW'(W_CTRL)) begin
        ctrl_en_q  <= reg_wdata[0];
        ctrl_sel_q <= req_sel;
      end
      if (reg_addr == AW'(W_TCFG)) begin
        t_stup_q <= reg_wdata[STUP_LSB +: STUP_W];
        t_samp_q <= reg_wdata[SAMP_LSB +: PH_W];
        t_div_q  <= reg_wdata[DIV_LSB  +: PH_W];
        t_cmp_q  <= reg_wdata[CMP_LSB  +: PH_W];
      end
      if (reg_addr == AW'(W_IEN)) ien_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lat_q <= '0;
      cur_ch_q  <= '0;
    end else if (start_evt) begin
      div_lat_q <= t_div_q;
      cur_ch_q  <= start_ch;
    end
  end

  // Completion has priority over a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ista_q <= 1'b0;
    else if (done_evt) ista_q <= 1'b1;
    else if (clr_evt)  ista_q <= 1'b0;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_code_q[g] <= '0;
        res_vld_q[g]  <= 1'b0;
      end else if (start_evt && (start_ch == CHW'(g))) begin
        res_vld_q[g] <= 1'b0;
      end else if (done_evt && (cur_ch_q == CHW'(g))) begin
        res_code_q[g] <= afe_data;
        res_vld_q[g]  <= 1'b1;
      end
    end
  end

  sar_seq_tick #(.DIVW(PH_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div_lat_q),
    .tick (tick)
  );

  sar_seq_fsm #(.LW(STUP_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_evt),
    .tick    (tick),
    .len_stup(t_stup_q),
    .len_samp(STUP_W'(t_samp_q)),
    .len_cmp (STUP_W'(t_cmp_q)),
    .phase   (phase),
    .busy    (busy),
    .done    (done_evt)
  );

  assign afe_sample  = (phase == PH_SAMPLE);
  assign afe_convert = (phase == PH_COMPARE);
  assign irq         = ista_q && ien_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(W_CTRL): begin
        reg_rdata[0]             = ctrl_en_q;
        reg_rdata[SEL_LSB +: NCH] = ctrl_sel_q;
      end
      AW'(W_STAT): reg_rdata[0] = busy;
      AW'(W_TCFG): begin
        reg_rdata[STUP_LSB +: STUP_W] = t_stup_q;
        reg_rdata[SAMP_LSB +: PH_W]   = t_samp_q;
        reg_rdata[DIV_LSB  +: PH_W]   = t_div_q;
        reg_rdata[CMP_LSB  +: PH_W]   = t_cmp_q;
      end
      AW'(W_IEN):  reg_rdata[0] = ien_q;
      AW'(W_ISTA): reg_rdata[0] = ista_q;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (reg_addr == AW'(W_RES0 + i)) begin
            reg_rdata[DW-1:0]   = res_code_q[i];
            reg_rdata[VALID_BIT] = res_vld_q[i];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic tick,
  input logic start_evt,
  input logic done_evt,
  input logic clr_evt,
  input logic ista,
  input logic irq,
  input logic afe_sample,
  input logic afe_convert
);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_evt);
  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt) |=> busy);
  a_r4_tick_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({afe_sample, afe_convert}));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!afe_sample && !afe_convert));
  a_r10_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (ista && !busy));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !done_evt) |=> !ista);
  a_r11_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !done_evt) |=> !irq);
endmodule

bind sar_seq sar_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .tick       (tick),
  .start_evt  (start_evt),
  .done_evt   (done_evt),
  .clr_evt    (clr_evt),
  .ista       (ista_q),
  .irq        (irq),
  .afe_sample (afe_sample),
  .afe_convert(afe_convert)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, afe_sample, afe_convert;
  logic [11:0] afe_data = '0;

  int checks = 0;
  int fails  = 0;
  int n_samp = 0, n_conv = 0;
  time t_srise = 0;
  logic prev_s = 1'b0;
  logic [11:0] exp_code [3];
  logic        exp_vld  [3];

  always #10 clk = ~clk;

  sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .afe_sample(afe_sample), .afe_convert(afe_convert), .afe_data(afe_data)
  );

  // Strobe monitor
  always @(negedge clk) begin
    if (afe_sample) n_samp++;
    if (afe_convert) n_conv++;
    if (afe_sample && !prev_s) t_srise = $time;
    prev_s = afe_sample;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = a[3:0];
    #1;
    d = reg_rdata;
  endtask

  function automatic int low_ch(input int sel);
    for (int i = 0; i < 3; i++) if (sel[i]) return i;
    return 0;
  endfunction

  task automatic check_results(input string req);
    logic [31:0] v;
    for (int i = 0; i < 3; i++) begin
      rd(5 + i, v);
      chk(req, v, {16'h0, exp_vld[i], 3'b000, exp_code[i]});
    end
  endtask

  // One conversion, optionally poked with a retrigger while busy
  task automatic run_conv(input int d, s, w, c, sel, input logic [11:0] code, input bit poke);
    logic [31:0] v;
    int ch, ns0, nc0, n, cyc, ticks;
    time t0;
    wr(3, (c << 16) | (d << 12) | (w << 8) | s);
    wr(1, 0);
    afe_data = code;
    ns0 = n_samp; nc0 = n_conv;
    wr(1, (sel << 5) | 1);
    t0 = $time;
    ch = low_ch(sel);
    rd(2, v); chk("R2 busy after start", v, 32'h1);
    rd(5 + ch, v); chk("R7 valid cleared at start", {31'h0, v[15]}, 32'h0);
    exp_vld[ch] = 1'b0;
    if (poke) begin
      wr(1, 0);
      wr(1, ((sel ^ 7) << 5) | 1);
    end
    n = 0;
    do begin
      @(negedge clk); rd(2, v); n++;
    end while (v[0] && n < 10000);
    cyc = int'(($time - t0) / 20);
    ticks = (s + 1) + (w + 1) + (c + 1);
    chk(poke ? "R9 busy length with retrigger" : "R4 busy length", cyc, ticks * (d + 1));
    chk("R5 sample strobe cycles", n_samp - ns0, (w + 1) * (d + 1));
    chk("R5 convert strobe cycles", n_conv - nc0, (c + 1) * (d + 1));
    chk("R5 sample starts after startup", int'((t_srise - t0) / 20), (s + 1) * (d + 1));
    exp_code[ch] = code; exp_vld[ch] = 1'b1;
    check_results(sel == (1 << ch) ? "R6 result placement" : "R8 lowest channel wins");
    rd(10, v); chk("R10 status set at end", v, 32'h1);
    wr(9, 1);
    rd(10, v); chk("R10 status cleared", v, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int i;
    for (int k = 0; k < 3; k++) begin exp_code[k] = '0; exp_vld[k] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, v); chk("R1 reset register", v, 32'h0);
    end
    chk("R1 irq low", irq, 1'b0);

    // R3 field layout
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); chk("R3 timing readback", v, 32'h000F_FF1F);
    wr(3, 32'h0003_2105);
    rd(3, v); chk("R3 timing fields", v, 32'h0003_2105);

    // R13 read-only and unmapped
    wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R13 status write ignored", v, 32'h0);
    wr(5, 32'hFFFF_FFFF); rd(5, v); chk("R13 result write ignored", v, 32'h0);
    wr(10, 32'hFFFF_FFFF); rd(10, v); chk("R13 istatus write ignored", v, 32'h0);
    rd(4, v); chk("R13 unmapped reads zero", v, 32'h0);
    rd(15, v); chk("R13 unmapped reads zero", v, 32'h0);

    // R12 enable without a channel
    wr(1, 0); wr(1, 1);
    rd(2, v); chk("R12 no channel no start", v, 32'h0);
    repeat (5) @(negedge clk);
    rd(10, v); chk("R12 no completion", v, 32'h0);

    // Sweep: divider, extreme phase lengths, every select pattern
    i = 0;
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++)
          for (int c = 0; c < 2; c++) begin
            run_conv(d, s * 31, w * 15, c * 15, (i % 7) + 1,
                     (i == 0) ? 12'h000 : (i == 1) ? 12'hFFF : 12'((i * 677 + 309) & 12'hFFF), 1'b0);
            i++;
          end

    // R9 retrigger while busy on a long conversion
    run_conv(3, 31, 2, 3, 3'b010, 12'hA5C, 1'b1);

    // R9 enable written again while already set: no start
    wr(1, (3'b100 << 5) | 1);
    rd(2, v); chk("R9 held enable no start", v, 32'h0);
    rd(7, v); chk("R9 held enable valid kept", {31'h0, v[15]}, {31'h0, exp_vld[2]});

    // R11 interrupt gating
    run_conv(0, 0, 0, 0, 3'b001, 12'h321, 1'b0);
    wr(1, 0); wr(1, (3'b001 << 5) | 1);
    repeat (6) @(negedge clk);
    chk("R11 irq masked", irq, 1'b0);
    wr(8, 1);
    chk("R11 irq when enabled", irq, 1'b1);
    wr(8, 0);
    chk("R11 irq follows enable", irq, 1'b0);
    wr(8, 1);
    wr(9, 1);
    chk("R11 irq gone after clear", irq, 1'b0);

    // R10 clear in the completing cycle: set wins (3 cycles, d=0)
    wr(3, 0);
    wr(1, 0);
    afe_data = 12'h0F0;
    wr(1, (3'b100 << 5) | 1);
    @(negedge clk);
    wr(9, 1);
    rd(10, v); chk("R10 set beats clear", v, 32'h1);
    chk("R11 irq on set-wins", irq, 1'b1);
    wr(9, 1);
    rd(10, v); chk("R10 plain clear", v, 32'h0);
    rd(7, v); chk("R6 channel 2 code", v, 32'h0000_80F0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule